// File: doc/BRIEF.md
# DMA Interrupt Aggregation Controller

This block merges the attention flags raised by the channels of a multi-channel DMA engine into one interrupt for the host. Each channel event is latched in a sticky attention bit, unless that channel's interrupt-disable input is high. The OR of all attention bits forms a summary status. The AND of that status with a master enable forms the gated interrupt.

Two delivery styles are selected by `msg_mode`. In legacy mode (`msg_mode` = 0) the gated interrupt drives `irq_level` as a level, one clock later. In message mode (`msg_mode` = 1) a one-cycle `irq_msg` request is issued on each low-to-high change of the gated interrupt. The block that encodes the bus message consumes this request.

Software reaches three registers through a simple single-cycle read/write bus. Read data is registered. Reading the control register clears the master enable, so the host has to re-arm the interrupt after each service pass.

Top module: `dmairq_aggregator`

## Requirements
- R1: Offset 0x01 reads 0x0000000C, the log2 of the largest transfer in bits 4:0, with all other bits zero. Writes to this offset have no effect.
- R2: Offset 0x03 is the control register: bit 0 master enable (read/write), bit 1 summary status (read-only), bit 2 gated interrupt (read-only), bits 31:3 read as zero.
- R3: An event on channel n sets attention bit n (offset 0x04, bits 3:0) on the next clock edge, unless disable input n is high. A disabled channel's event leaves its bit clear.
- R4: Writing a 1 to an attention bit clears that bit. Writing a 0 leaves the bit unchanged. Bits 31:4 read as zero.
- R5: When an event and a write-1 clear hit the same attention bit in the same cycle, the bit ends up set.
- R6: The summary status is the OR of the four attention bits.
- R7: The gated interrupt is the summary status ANDed with the master enable. A write to offset 0x03 loads the enable from bit 0.
- R8: A read of offset 0x03 returns the enable value from before the read. The enable reads as clear from the next cycle onward. If a write and a read of 0x03 fall in the same cycle, the read's clear wins.
- R9: In legacy mode, `irq_level` equals the gated interrupt one clock later, and `irq_msg` stays low.
- R10: In message mode, `irq_msg` is high for exactly one cycle for each low-to-high change of the gated interrupt. A gated interrupt that stays high gives no further pulses, and `irq_level` stays low.
- R11: While the master enable is clear, neither `irq_level` nor `irq_msg` is raised.
- R12: After reset, the attention bits, the enable, `reg_rdata`, `irq_level` and `irq_msg` are all zero.
- R13: A read of any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_evt | input | 4 | Per-channel attention event strobes |
| chan_dis | input | 4 | Per-channel interrupt-disable inputs |
| msg_mode | input | 1 | 0 = level interrupt, 1 = message request pulses |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq_level | output | 1 | Level interrupt (legacy mode) |
| irq_msg | output | 1 | One-cycle message request (message mode) |

## Verification
Two pairs of functions can land in the same clock cycle. The first pair is a channel event and a write-1 clear of the same attention bit. The bench drives both strobes in one cycle and then reads the attention register, expecting the bit to be set. The second pair is a software write of the master enable and the read that auto-clears it. The bench issues both in one cycle and checks two things: the read data shows the enable as it was before the read, and a later read shows it clear.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_CAP  = 8'h01;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h03;
  localparam logic [ADDR_W-1:0] OFS_ATTN = 8'h04;

  typedef struct packed {
    logic gated;
    logic summary;
    logic enable;
  } ctrl_view_t;
endpackage

// File: rtl/dmairq_attn_bank.sv
module dmairq_attn_bank #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] evt,
  input  logic [NCH-1:0] dis,
  input  logic           clr_en,
  input  logic [NCH-1:0] clr_mask,
  output logic [NCH-1:0] attn
);
  logic [NCH-1:0] set_v;
  logic [NCH-1:0] clr_v;

  assign set_v = evt & ~dis;
  assign clr_v = clr_en ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) attn <= '0;
    else     attn <= (attn & ~clr_v) | set_v;
  end

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
    (|set_v) |=> ((attn & $past(set_v)) == $past(set_v))); // R5
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (|(clr_v & ~set_v)) |=> ((attn & $past(clr_v & ~set_v)) == '0)); // R4
  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (|(dis & ~attn)) |=> ((attn & $past(dis & ~attn)) == '0)); // R3
endmodule

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic rd_en,
  input  logic summary,
  output logic enable,
  output logic gated
);
  always_ff @(posedge clk) begin
    if (rst)        enable <= 1'b0;
    else if (rd_en) enable <= 1'b0;
    else if (wr_en) enable <= wr_bit;
  end

  assign gated = summary & enable;

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !enable); // R8
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en) |=> (enable == $past(wr_bit))); // R7
endmodule

// File: rtl/dmairq_signal.sv
module dmairq_signal (
  input  logic clk,
  input  logic rst,
  input  logic msg_mode,
  input  logic gated,
  output logic irq_level,
  output logic irq_msg
);
  logic gated_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gated_q   <= 1'b0;
      irq_level <= 1'b0;
      irq_msg   <= 1'b0;
    end else begin
      gated_q   <= gated;
      irq_level <= gated & ~msg_mode;
      irq_msg   <= gated & ~gated_q & msg_mode;
    end
  end

  AST_MSG_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq_msg |=> !irq_msg); // R10
endmodule

// File: rtl/dmairq_aggregator.sv
module dmairq_aggregator #(
  parameter int NCH      = 4,
  parameter int CAP_LOG2 = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  chan_evt,
  input  logic [3:0]  chan_dis,
  input  logic        msg_mode,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_level,
  output logic        irq_msg
);
  import dmairq_pkg::*;

  localparam int CAP_W = 5;

  logic [NCH-1:0] attn;
  logic           summary;
  logic           enable;
  logic           gated;
  logic           hit_ctrl;
  logic           hit_attn;
  ctrl_view_t     cview;
  logic [DATA_W-1:0] rd_mux;
  logic           unused_wdata;

  assign hit_ctrl     = (reg_addr == OFS_CTRL);
  assign hit_attn     = (reg_addr == OFS_ATTN);
  assign unused_wdata = ^reg_wdata;

  dmairq_attn_bank #(.NCH(NCH)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .evt      (chan_evt[NCH-1:0]),
    .dis      (chan_dis[NCH-1:0]),
    .clr_en   (reg_wr & hit_attn),
    .clr_mask (reg_wdata[NCH-1:0]),
    .attn     (attn)
  );

  assign summary = |attn;

  dmairq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr & hit_ctrl),
    .wr_bit  (reg_wdata[0]),
    .rd_en   (reg_rd & hit_ctrl),
    .summary (summary),
    .enable  (enable),
    .gated   (gated)
  );

  dmairq_signal u_sig (
    .clk       (clk),
    .rst       (rst),
    .msg_mode  (msg_mode),
    .gated     (gated),
    .irq_level (irq_level),
    .irq_msg   (irq_msg)
  );

  assign cview = '{gated: gated, summary: summary, enable: enable};

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      OFS_CAP:  rd_mux[CAP_W-1:0] = CAP_W'(CAP_LOG2);
      OFS_CTRL: rd_mux[2:0]       = cview;
      OFS_ATTN: rd_mux[NCH-1:0]   = attn;
      default:  rd_mux            = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  AST_LEVEL_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_level |-> $past(enable)); // R11
  AST_MSG_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_msg |-> $past(enable)); // R11
  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (rst)
    !msg_mode |=> (irq_level == $past(enable && (attn != '0)))); // R9
endmodule

// File: tb/dmairq_aggregator_tb.sv
`timescale 1ns/1ps
module dmairq_aggregator_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  chan_evt = '0;
  logic [3:0]  chan_dis = '0;
  logic        msg_mode = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_level;
  logic        irq_msg;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dmairq_aggregator dut_i (
    .clk(clk), .rst(rst), .chan_evt(chan_evt), .chan_dis(chan_dis),
    .msg_mode(msg_mode), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_level(irq_level), .irq_msg(irq_msg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic bus(input logic w, input logic r, input logic [7:0] a,
                     input logic [31:0] d, output logic [31:0] q);
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    q = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] q;
    bus(1'b1, 1'b0, a, d, q);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] q);
    bus(1'b0, 1'b1, a, '0, q);
  endtask

  task automatic pulse(input logic [3:0] e);
    chan_evt = e;
    cyc();
    chan_evt = '0;
  endtask

  task automatic count_msg(input int n, output int pulses, output int levels);
    pulses = 0; levels = 0;
    for (int i = 0; i < n; i++) begin
      cyc();
      if (irq_msg) pulses++;
      if (irq_level) levels++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] q;
    check("R12 irq_level after reset", 32'(irq_level), 0);
    check("R12 irq_msg after reset", 32'(irq_msg), 0);
    check("R12 rdata after reset", reg_rdata, 0);
    rd(8'h03, q); check("R12 ctrl after reset", q, 0);
    rd(8'h04, q); check("R12 attn after reset", q, 0);
  endtask

  task automatic t_cap();
    logic [31:0] q;
    rd(8'h01, q); check("R1 capacity value", q, 32'h0C);
    wr(8'h01, 32'hFFFF_FFFF);
    rd(8'h01, q); check("R1 capacity read-only", q, 32'h0C);
    rd(8'h02, q); check("R13 unmapped 0x02", q, 0);
    rd(8'h05, q); check("R13 unmapped 0x05", q, 0);
  endtask

  task automatic t_attn();
    logic [31:0] q;
    pulse(4'b0101);
    rd(8'h04, q); check("R3 events latched", q, 32'h5);
    rd(8'h03, q); check("R6 R2 summary bit set", q, 32'h2);
    chan_dis = 4'b1000;
    pulse(4'b1000);
    chan_dis = '0;
    rd(8'h04, q); check("R3 disabled channel ignored", q, 32'h5);
    wr(8'h04, 32'hFFFF_FFF1);
    rd(8'h04, q); check("R4 write-1 clears bit0", q, 32'h4);
    wr(8'h04, 32'h0);
    rd(8'h04, q); check("R4 write-0 no effect", q, 32'h4);
    wr(8'h04, 32'h4);
    rd(8'h04, q); check("R4 all cleared", q, 0);
    rd(8'h03, q); check("R6 summary clear", q, 0);
  endtask

  task automatic t_simul();
    logic [31:0] q;
    pulse(4'b0001);
    chan_evt = 4'b0001;
    wr(8'h04, 32'h1);
    chan_evt = '0;
    rd(8'h04, q); check("R5 event beats clear", q, 32'h1);
    wr(8'h04, 32'hF);
    rd(8'h04, q); check("R5 later clear works", q, 0);
  endtask

  task automatic t_legacy();
    logic [31:0] q;
    int p, l;
    msg_mode = 1'b0;
    wr(8'h03, 32'h1);
    pulse(4'b0010);
    check("R9 level one cycle late", 32'(irq_level), 0);
    cyc();
    check("R9 level asserted", 32'(irq_level), 1);
    check("R9 no msg in legacy", 32'(irq_msg), 0);
    rd(8'h03, q); check("R8 R7 R2 read shows pre-read enable", q, 32'h7);
    cyc();
    check("R11 level drops after auto-clear", 32'(irq_level), 0);
    rd(8'h03, q); check("R8 enable cleared", q, 32'h2);
    pulse(4'b0100);
    count_msg(5, p, l);
    check("R11 no level while disabled", 32'(l), 0);
    wr(8'h04, 32'hF);
  endtask

  task automatic t_msg();
    logic [31:0] q;
    int p, l;
    msg_mode = 1'b1;
    wr(8'h03, 32'h1);
    pulse(4'b0100);
    count_msg(6, p, l);
    check("R10 one pulse on rise", 32'(p), 1);
    check("R10 no level in msg mode", 32'(l), 0);
    pulse(4'b1000);
    count_msg(6, p, l);
    check("R10 held high gives no pulse", 32'(p), 0);
    rd(8'h03, q);
    count_msg(6, p, l);
    check("R11 no pulse with enable clear", 32'(p), 0);
    wr(8'h03, 32'h1);
    count_msg(6, p, l);
    check("R10 re-arm gives new pulse", 32'(p), 1);
    rd(8'h03, q);
    wr(8'h04, 32'hF);
    msg_mode = 1'b0;
  endtask

  task automatic t_rw_same();
    logic [31:0] q;
    wr(8'h03, 32'h1);
    bus(1'b1, 1'b1, 8'h03, 32'h1, q);
    check("R8 same-cycle read sees old enable", q, 32'h1);
    rd(8'h03, q); check("R8 read clear beats write", q, 0);
  endtask

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    t_reset();
    t_cap();
    t_attn();
    t_simul();
    t_legacy();
    t_msg();
    t_rw_same();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule